// File: doc/BRIEF.md
# Sigma-Delta Bitstream Receiver Front End

This block is the per-channel receiving front end for a single-bit stream coming from an external sigma-delta modulator. It produces a programmable divided clock from the system clock, which can drive the modulator. It chooses whether the sampling clock is an external clock pin or that divided clock, and it turns the data line into a stream of decoded bits.

Two decoding families are supported. In the clocked serial mode, data is captured on the rising or the falling transition of the chosen clock. In Manchester mode, no clock is used. The bit timing is recovered from the data transitions themselves, and the nominal bit period is taken from the divider setting. Every external input is first brought into the system clock domain. All clock and data edges are found by comparing samples taken on the system clock. The result is a one-cycle strobe with the decoded bit beside it, which the downstream filter and the monitoring logic consume.

Top module: `sdm_serial_frontend`

## Requirements
- R1: With `div_cfg` = D in 1..255, `clk_out` repeats every D+1 system cycles and is high for floor((D+1)/2) of them.
- R2: With `div_cfg` = 0, `clk_out` stays low.
- R3: `csel` = 0 selects the synchronised `ext_clk_i` as the sampling clock. Any other `csel` value selects `clk_out`.
- R4: `itype` = 0 captures the synchronised `data_i` on each rising transition of the sampling clock. `itype` = 1 captures it on each falling transition. Each capture gives one strobe carrying the captured level.
- R5: `itype` = 2 is Manchester decoding in which a rising data transition gives bit 1 and a falling one gives bit 0. `itype` = 3 inverts that mapping. The bit period is `div_cfg`+1 cycles, with `div_cfg` of 3 or more. A transition is accepted only when at least floor(3*(`div_cfg`+1)/4) cycles have passed since the previously accepted one. The first transition after enable is always accepted as a mid-bit transition.
- R6: `bit_valid` is never high on two consecutive cycles, and `bit_data` changes only together with a `bit_valid` pulse.
- R7: While `en` is low, no strobe is produced. A clock or data level that is already present when `en` rises does not cause a strobe.
- R8: Under reset, `clk_out`, `bit_valid` and `bit_data` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Channel enable |
| div_cfg | input | 8 | Divider setting: ratio is value+1, 0 turns the clock off |
| itype | input | 2 | Decoding type: 0 serial rising, 1 serial falling, 2/3 Manchester |
| csel | input | 2 | Sampling clock source: 0 external pin, otherwise divided clock |
| ext_clk_i | input | 1 | External modulator clock pin |
| data_i | input | 1 | Modulator data pin |
| clk_out | output | 1 | Divided output clock |
| bit_valid | output | 1 | One-cycle strobe for each decoded bit |
| bit_data | output | 1 | Decoded bit value, held between strobes |

## Verification
The single-pulse property assumes that the chosen clock holds each level for at least two system cycles. It also assumes that Manchester traffic runs with a ratio of four or more. The bench therefore holds each external clock phase for three cycles and only uses Manchester ratios of 8 and 12.

The data must be stable around the active clock transition. The bench sets data three cycles before that transition and keeps it three cycles after. Manchester streams begin at the first half-bit level of the first bit, so the first transition the decoder sees is a mid-bit one. The high-time property of the divider assumes `div_cfg` is stable, and the bench changes it only between measurement windows.

// File: rtl/sdm_fe_pkg.sv
package sdm_fe_pkg;

   localparam logic [1:0] IT_SER_RISE = 2'd0;
   localparam logic [1:0] IT_SER_FALL = 2'd1;
   localparam logic [1:0] IT_MAN_R1   = 2'd2;
   localparam logic [1:0] IT_MAN_R0   = 2'd3;

   localparam logic [1:0] CSRC_EXT    = 2'd0;

   function automatic logic is_manch(input logic [1:0] t);
      return (t == IT_MAN_R1) || (t == IT_MAN_R0);
   endfunction

endpackage

// File: rtl/sdm_fe_sync.sv
module sdm_fe_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] st;

   initial assert (STAGES >= 2) else $fatal(1, "sdm_fe_sync: STAGES must be 2 or more");

   always_ff @(posedge clk) begin
      if (!rst_n) st <= '0;
      else        st <= {st[STAGES-2:0], d};
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/sdm_fe_clkdiv.sv
module sdm_fe_clkdiv #(
   parameter int CFG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] div_cfg,
   output logic             clk_o
);

   localparam int RW = CFG_W + 1;

   logic [CFG_W-1:0] cnt;
   logic [CFG_W-1:0] cnt_nxt;
   logic [RW-1:0]    ratio;
   logic [RW-1:0]    half;

   assign ratio   = {1'b0, div_cfg} + RW'(1);
   assign half    = ratio >> 1;
   assign cnt_nxt = (cnt >= div_cfg) ? '0 : cnt + CFG_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         clk_o <= 1'b0;
      end else if (div_cfg == '0) begin
         cnt   <= '0;
         clk_o <= 1'b0;
      end else begin
         cnt   <= cnt_nxt;
         clk_o <= ({1'b0, cnt_nxt} < half);
      end
   end

endmodule

// File: rtl/sdm_fe_edge.sv
module sdm_fe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sig,
   output logic rise,
   output logic fall
);

   logic prev;

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= sig;
   end

   assign rise = en &  sig & ~prev;
   assign fall = en & ~sig &  prev;

endmodule

// File: rtl/sdm_fe_manch.sv
module sdm_fe_manch #(
   parameter int CFG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CFG_W-1:0] div_cfg,
   input  logic             pol,
   input  logic             rise,
   input  logic             fall,
   output logic             take,
   output logic             val
);

   localparam int CW = CFG_W + 2;
   localparam int TW = CFG_W + 3;
   localparam logic [CW-1:0] CMAX = '1;

   logic [CW-1:0] cnt;
   logic [TW-1:0] ratio;
   logic [TW-1:0] thr;

   assign ratio = {3'b000, div_cfg} + TW'(1);
   assign thr   = (ratio + (ratio << 1)) >> 2;
   assign take  = en && (rise || fall) && ({1'b0, cnt} >= thr);
   assign val   = rise ^ pol;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= CMAX;
      else if (!en)        cnt <= CMAX;
      else if (take)       cnt <= CW'(1);
      else if (cnt != CMAX) cnt <= cnt + CW'(1);
   end

endmodule

// File: rtl/sdm_serial_frontend.sv
module sdm_serial_frontend
   import sdm_fe_pkg::*;
#(
   parameter int CFG_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MANCH_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CFG_W-1:0] div_cfg,
   input  logic [1:0]       itype,
   input  logic [1:0]       csel,
   input  logic             ext_clk_i,
   input  logic             data_i,
   output logic             clk_out,
   output logic             bit_valid,
   output logic             bit_data
);

   initial assert (CFG_W >= 2) else $fatal(1, "sdm_serial_frontend: CFG_W too small");

   logic [1:0] sync_q;
   logic       ext_s, dat_s;
   logic       sel_clk;
   logic       ck_rise, ck_fall, d_rise, d_fall;
   logic       ser_take, man_take, man_val;
   logic       take, val;

   sdm_fe_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .d ({ext_clk_i, data_i}), .q (sync_q)
   );
   assign {ext_s, dat_s} = sync_q;

   sdm_fe_clkdiv #(.CFG_W(CFG_W)) u_div (
      .clk (clk), .rst_n (rst_n), .div_cfg (div_cfg), .clk_o (clk_out)
   );

   assign sel_clk = (csel == CSRC_EXT) ? ext_s : clk_out;

   sdm_fe_edge u_ck_edge (
      .clk (clk), .rst_n (rst_n), .en (en), .sig (sel_clk),
      .rise (ck_rise), .fall (ck_fall)
   );

   sdm_fe_edge u_d_edge (
      .clk (clk), .rst_n (rst_n), .en (en), .sig (dat_s),
      .rise (d_rise), .fall (d_fall)
   );

   assign ser_take = !is_manch(itype) &&
                     ((itype == IT_SER_FALL) ? ck_fall : ck_rise);

   generate
      if (MANCH_EN) begin : g_manch
         sdm_fe_manch #(.CFG_W(CFG_W)) u_manch (
            .clk (clk), .rst_n (rst_n), .en (en), .div_cfg (div_cfg),
            .pol (itype == IT_MAN_R0), .rise (d_rise), .fall (d_fall),
            .take (man_take), .val (man_val)
         );
      end else begin : g_no_manch
         assign man_take = 1'b0;
         assign man_val  = 1'b0;
      end
   endgenerate

   assign take = ser_take || (is_manch(itype) && man_take);
   assign val  = is_manch(itype) ? man_val : dat_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_valid <= 1'b0;
         bit_data  <= 1'b0;
      end else begin
         bit_valid <= en && take;
         if (en && take) bit_data <= val;
      end
   end

endmodule

// File: rtl/sdm_fe_checker.sv
module sdm_fe_checker #(
   parameter int CFG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [CFG_W-1:0] div_cfg,
   input logic             clk_out,
   input logic             bit_valid,
   input logic             bit_data
);

   // R7: a low enable suppresses the strobe on the following cycle
   p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !bit_valid);

   // R6: strobes are isolated single-cycle pulses
   p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |=> !bit_valid);

   // R6: the bit value only moves with a strobe
   p_data_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_valid |-> $stable(bit_data));

   // R2: a zero divider setting keeps the output clock low
   p_clk_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (div_cfg == '0) |=> !clk_out);

   // R1: with ratio 4 or more the high phase lasts at least two cycles
   p_high_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(clk_out) && (div_cfg >= CFG_W'(3)) && $stable(div_cfg)) |=> clk_out);

endmodule

bind sdm_serial_frontend sdm_fe_checker #(.CFG_W(CFG_W)) u_chk (
   .clk (clk), .rst_n (rst_n), .en (en), .div_cfg (div_cfg),
   .clk_out (clk_out), .bit_valid (bit_valid), .bit_data (bit_data)
);

// File: tb/tb_sdm_serial_frontend.sv
module tb_sdm_serial_frontend;

   logic       clk = 1'b0;
   logic       rst_n, en;
   logic [7:0] div_cfg;
   logic [1:0] itype, csel;
   logic       ext_clk_i, data_i;
   wire        clk_out, bit_valid, bit_data;

   int n_chk = 0;
   int n_bad = 0;
   bit got[$];

   always #5 clk = ~clk;

   sdm_serial_frontend dut (
      .clk (clk), .rst_n (rst_n), .en (en), .div_cfg (div_cfg),
      .itype (itype), .csel (csel), .ext_clk_i (ext_clk_i), .data_i (data_i),
      .clk_out (clk_out), .bit_valid (bit_valid), .bit_data (bit_data)
   );

   always @(negedge clk) if (rst_n === 1'b1 && bit_valid === 1'b1) got.push_back(bit_data);

   task automatic chk(input string rq, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic compare(input string rq, input bit exp[]);
      idle(8);
      chk({rq, " count"}, got.size(), exp.size());
      for (int i = 0; i < exp.size() && i < got.size(); i++) chk(rq, got[i], exp[i]);
   endtask

   // serial capture on the external clock
   task automatic ser_run(input bit fall_mode, input int nbits);
      bit b[];
      b = new[nbits];
      foreach (b[i]) b[i] = bit'($urandom_range(0, 1));
      en = 1'b0; csel = 2'd0; itype = fall_mode ? 2'd1 : 2'd0;
      ext_clk_i = fall_mode;
      idle(4); en = 1'b1; idle(4);
      got.delete();
      foreach (b[i]) begin
         data_i = b[i]; idle(3);
         ext_clk_i = !fall_mode; idle(3);
         ext_clk_i = fall_mode; idle(3);
      end
      compare("R4 serial", b);
   endtask

   // Manchester stream; first half-bit level is b ^ (code 2)
   task automatic man_run(input bit inv, input int dv, input int nbits);
      bit b[];
      int half;
      bit first;
      b = new[nbits];
      foreach (b[i]) b[i] = bit'($urandom_range(0, 1));
      half = (dv + 1) / 2;
      en = 1'b0; div_cfg = 8'(dv); itype = inv ? 2'd3 : 2'd2;
      data_i = b[0] ^ !inv;
      idle(4); en = 1'b1; idle(4);
      got.delete();
      foreach (b[i]) begin
         first = b[i] ^ !inv;
         data_i = first;  idle(half);
         data_i = !first; idle(half);
      end
      compare("R5 manchester", b);
   endtask

   // count rises and high samples of clk_out over a window
   task automatic div_measure(input int dv, input int periods);
      int rises, highs;
      bit prev;
      div_cfg = 8'(dv);
      idle(2 * (dv + 1) + 4);
      rises = 0; highs = 0; prev = clk_out;
      repeat (periods * (dv + 1)) begin
         @(negedge clk);
         if (clk_out && !prev) rises++;
         if (clk_out) highs++;
         prev = clk_out;
      end
      chk("R1 rises", rises, periods);
      chk("R1 high cycles", highs, periods * ((dv + 1) / 2));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int cnt1;
      void'($urandom(32'h5D1F_0A73));
      rst_n = 1'b0; en = 1'b0; div_cfg = 8'd0; itype = 2'd0; csel = 2'd0;
      ext_clk_i = 1'b0; data_i = 1'b0;
      idle(5);
      // R8 reset state
      chk("R8 clk_out", clk_out, 0);
      chk("R8 bit_valid", bit_valid, 0);
      chk("R8 bit_data", bit_data, 0);
      rst_n = 1'b1;
      idle(3);

      // R2 divider off
      cnt1 = 0;
      repeat (60) begin @(negedge clk); if (clk_out) cnt1++; end
      chk("R2 clk off", cnt1, 0);

      // R1 divider ratios, including the extremes
      div_measure(1, 20);
      div_measure(4, 12);
      div_measure(7, 10);
      div_measure(255, 2);

      // R7 disabled: toggling clock gives nothing
      div_cfg = 8'd0; en = 1'b0; csel = 2'd0; itype = 2'd0;
      got.delete();
      repeat (10) begin data_i = 1'b1; ext_clk_i = 1'b1; idle(3); ext_clk_i = 1'b0; idle(3); end
      idle(6);
      chk("R7 disabled strobes", got.size(), 0);
      // R7 clock already high at enable
      ext_clk_i = 1'b1; idle(5);
      en = 1'b1; idle(20);
      chk("R7 level at enable", got.size(), 0);
      ext_clk_i = 1'b0; idle(4);

      // R4 directed then random serial captures
      ser_run(1'b0, 8);
      ser_run(1'b1, 8);
      for (int r = 0; r < 6; r++) ser_run(bit'($urandom_range(0, 1)), 12);

      // R3 internal clock source, ratio 8: 10 strobes per 80 cycles
      div_cfg = 8'd7; itype = 2'd0; data_i = 1'b1; ext_clk_i = 1'b0;
      for (int s = 1; s < 4; s++) begin
         csel = 2'(s); idle(20);
         got.delete();
         idle(80);
         cnt1 = 0;
         foreach (got[i]) if (got[i]) cnt1++;
         chk("R3 internal strobes", got.size(), 10);
         chk("R3 internal data", cnt1, 10);
      end
      // R3 external selected with a static pin while clk_out runs
      csel = 2'd0; idle(10);
      got.delete(); idle(80);
      chk("R3 external static", got.size(), 0);

      // R4 falling edge on the internal clock with data low
      csel = 2'd1; itype = 2'd1; data_i = 1'b0; idle(20);
      got.delete(); idle(80);
      cnt1 = 0;
      foreach (got[i]) if (got[i]) cnt1++;
      chk("R4 falling internal strobes", got.size(), 10);
      chk("R4 falling internal data", cnt1, 0);

      // R5 Manchester both polarities, two bit periods
      man_run(1'b0, 7, 10);
      man_run(1'b1, 7, 10);
      for (int r = 0; r < 6; r++)
         man_run(bit'($urandom_range(0, 1)), ($urandom_range(0, 1) != 0) ? 7 : 11, 16);

      en = 1'b0; idle(10);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule